// File: doc/BRIEF.md
# Pipelined Late-Write Synchronous SRAM

This block is a single-port synchronous static memory that reads in pipeline mode and writes with a late write. On every rising clock edge it captures the address, the select, the global write enable and the per-lane write enables. A read returns its word from an output register one clock later. A write supplies its data on the edge after the one that took its address. The block holds that data in a posted write buffer and puts it into the storage array later, in a cycle when the array port is free.

A read that hits the address held in the write buffer takes the enabled lanes of the buffered word. It takes the other lanes from the array, so a read issued straight after a write always sees the new data. An asynchronous output enable gates the data outputs without any clock edge. A synchronous sleep input stops all array traffic while it is asserted.

Top module: `lw_sram`

## Requirements
- R1: A synchronous active-low reset clears the output register to zero and marks the write buffer empty. No read after reset returns buffered data until a new write is made.
- R2: A read captured at clock edge N appears on `rdata_o` after edge N+1. The output register keeps that value until the next read is captured, whatever happens in other cycles.
- R3: The write data for a write captured at edge N is taken from `wdata_i` at edge N+1. The value on `wdata_i` in the address cycle is ignored.
- R4: The word is split into 9-bit lanes: lane k holds bits 9k to 9k+8, and `lane_we_i[k]` enables it. Lane enables count only when `we_i` is 1, and a selected cycle with `we_i` at 0 is a read. A write leaves its disabled lanes unchanged.
- R5: A read whose address equals the buffered write returns the enabled lanes of that write from the buffer and the other lanes from the array.
- R6: Back-to-back writes, including partial writes to the same address, all reach memory. A later read returns the newest data in every lane.
- R7: A cycle captured with `cs_i` at 0 performs neither a read nor a write. Memory contents and `rdata_o` stay unchanged.
- R8: A cycle captured with `sleep_i` at 1 performs no read and does not write the array. A write still waiting in the buffer survives the sleep.
- R9: While `oe_i` is 0, `rdata_o` is all zeros and `drive_o` is 0. When `oe_i` returns to 1, the held output register value appears, with no clock edge needed.
- R10: The buffered write goes into the array only in a cycle that is neither a read nor asleep, which means a write cycle or an idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all capture happens on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_i | input | 1 | Synchronous select; 0 makes the cycle idle |
| we_i | input | 1 | Global write enable; 0 means read |
| lane_we_i | input | LANES | Per-lane write enables, bit k for lane k |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | LANES*LANE_W | Write data, one cycle after its address |
| sleep_i | input | 1 | Synchronous sleep; 1 blocks array access |
| oe_i | input | 1 | Asynchronous output enable |
| rdata_o | output | LANES*LANE_W | Read data, zero while the output is disabled |
| drive_o | output | 1 | Output drive enable; 0 stands for high impedance |

## Verification
A buffer that drops or keeps an entry at the wrong time can look correct while it is being forwarded. It shows up at the ports as stale lanes on a later read of that address, once a write or idle cycle should have committed it. Bad address or lane capture shows up in the read that follows two edges later. A wrong merge shows up as mixed old and new lanes in the very next read of the address. An output register that reloads on non-read cycles shows up one edge later as a changed `rdata_o` after a deselected or sleeping cycle.

// File: rtl/lw_sram_pkg.sv
// Shared types for the late-write SRAM.
// Assumes: the control register stage encodes each captured cycle as one op.
package lw_sram_pkg;

    // Kind of access captured at a clock edge.
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

endpackage

// File: rtl/lw_sram_ctrl.sv
// Input capture stage: registers address, lane mask and the cycle kind.
// Assumes: select and sleep are sampled on the same edge as the address;
// lane enables are only meaningful when the global write enable is high.
module lw_sram_ctrl
    import lw_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_i,
    input  logic              we_i,
    input  logic [LANES-1:0]  lane_we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              sleep_i,
    output op_e               op_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [LANES-1:0]  mask_q,
    output logic              sleep_q
);

    op_e op_d;

    // Decode the access kind from select, sleep and global write enable.
    always_comb begin
        if (!cs_i || sleep_i) begin
            op_d = OP_IDLE;
        end else if (we_i) begin
            op_d = OP_WRITE;
        end else begin
            op_d = OP_READ;
        end
    end

    // Register the captured cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= OP_IDLE;
            addr_q  <= '0;
            mask_q  <= '0;
            sleep_q <= 1'b0;
        end else begin
            op_q    <= op_d;
            addr_q  <= addr_i;
            mask_q  <= we_i ? lane_we_i : '0;
            sleep_q <= sleep_i;
        end
    end

endmodule

// File: rtl/lw_sram_array.sv
// Storage array: one memory per byte lane, asynchronous read, lane-masked write.
// Assumes: at most one write per clock; contents are not reset.
module lw_sram_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LANES-1:0]        wr_mask,
    input  logic [LANES*LANE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [LANES*LANE_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        // Write this lane when the commit enables it.
        always_ff @(posedge clk) begin
            if (wr_en && wr_mask[g]) begin
                mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
            end
        end

        // Read this lane combinationally.
        assign rd_data[g*LANE_W +: LANE_W] = mem[rd_addr];
    end

endmodule

// File: rtl/lw_sram_wbuf.sv
// Posted write buffer with address match and lane-wise read forwarding.
// Assumes: a write op in the control stage is completed by wdata on the next
// edge; the array port is taken by a read only in a read op cycle.
module lw_sram_wbuf
    import lw_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  op_e                     op,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES-1:0]        mask,
    input  logic                    sleep_q,
    input  logic [LANES*LANE_W-1:0] wdata_i,
    input  logic [LANES*LANE_W-1:0] arr_rdata,
    output logic                    commit_o,
    output logic [ADDR_W-1:0]       cm_addr_o,
    output logic [LANES-1:0]        cm_mask_o,
    output logic [LANES*LANE_W-1:0] cm_data_o,
    output logic                    buf_vld_o,
    output logic [LANES*LANE_W-1:0] rd_merged_o
);

    localparam int DATA_W = LANES * LANE_W;

    logic              buf_vld;
    logic [ADDR_W-1:0] buf_addr;
    logic [LANES-1:0]  buf_mask;
    logic [DATA_W-1:0] buf_data;
    logic              hit;

    // Drain the buffer whenever the array port is free and awake.
    assign commit_o  = buf_vld && (op != OP_READ) && !sleep_q;
    assign cm_addr_o = buf_addr;
    assign cm_mask_o = buf_mask;
    assign cm_data_o = buf_data;
    assign buf_vld_o = buf_vld;

    // Load a completed write or clear the entry after its commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_vld  <= 1'b0;
            buf_addr <= '0;
            buf_mask <= '0;
            buf_data <= '0;
        end else if (op == OP_WRITE) begin
            buf_vld  <= 1'b1;
            buf_addr <= addr;
            buf_mask <= mask;
            buf_data <= wdata_i;
        end else if (commit_o) begin
            buf_vld  <= 1'b0;
        end
    end

    // Compare the read address with the buffered write.
    assign hit = buf_vld && (buf_addr == addr);

    for (genvar g = 0; g < LANES; g++) begin : g_fwd
        // Pick the buffered lane when it is enabled and the address hits.
        assign rd_merged_o[g*LANE_W +: LANE_W] = (hit && buf_mask[g])
            ? buf_data[g*LANE_W +: LANE_W]
            : arr_rdata[g*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/lw_sram.sv
// Pipelined late-write synchronous SRAM top.
// Assumes: write data follows its address by one clock; read data is taken
// from the output register one clock after the address edge; the output
// enable acts without a clock.
module lw_sram
    import lw_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cs_i,
    input  logic                    we_i,
    input  logic [LANES-1:0]        lane_we_i,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [LANES*LANE_W-1:0] wdata_i,
    input  logic                    sleep_i,
    input  logic                    oe_i,
    output logic [LANES*LANE_W-1:0] rdata_o,
    output logic                    drive_o
);

    localparam int DATA_W = LANES * LANE_W;

    op_e               op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LANES-1:0]  mask_q;
    logic              sleep_q;
    logic              commit;
    logic [ADDR_W-1:0] cm_addr;
    logic [LANES-1:0]  cm_mask;
    logic [DATA_W-1:0] cm_data;
    logic              buf_vld;
    logic [DATA_W-1:0] arr_rdata;
    logic [DATA_W-1:0] merged;
    logic [DATA_W-1:0] dout_q;

    lw_sram_ctrl #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_i      (cs_i),
        .we_i      (we_i),
        .lane_we_i (lane_we_i),
        .addr_i    (addr_i),
        .sleep_i   (sleep_i),
        .op_q      (op_q),
        .addr_q    (addr_q),
        .mask_q    (mask_q),
        .sleep_q   (sleep_q)
    );

    lw_sram_wbuf #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_wbuf (
        .clk         (clk),
        .rst_n       (rst_n),
        .op          (op_q),
        .addr        (addr_q),
        .mask        (mask_q),
        .sleep_q     (sleep_q),
        .wdata_i     (wdata_i),
        .arr_rdata   (arr_rdata),
        .commit_o    (commit),
        .cm_addr_o   (cm_addr),
        .cm_mask_o   (cm_mask),
        .cm_data_o   (cm_data),
        .buf_vld_o   (buf_vld),
        .rd_merged_o (merged)
    );

    lw_sram_array #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_array (
        .clk     (clk),
        .wr_en   (commit),
        .wr_addr (cm_addr),
        .wr_mask (cm_mask),
        .wr_data (cm_data),
        .rd_addr (addr_q),
        .rd_data (arr_rdata)
    );

    // Load the output register with the merged word on read cycles only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q <= '0;
        end else if (op_q == OP_READ) begin
            dout_q <= merged;
        end
    end

    // Gate the data outputs with the asynchronous output enable.
    assign rdata_o = oe_i ? dout_q : '0;
    assign drive_o = oe_i;

endmodule

// File: rtl/lw_sram_chk.sv
// Assertion checker for lw_sram, attached through bind.
// Assumes: synchronous active-low reset; op encoding from lw_sram_pkg.
module lw_sram_chk
    import lw_sram_pkg::*;
#(
    parameter int DATA_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_i,
    input logic              sleep_i,
    input logic              oe_i,
    input logic [DATA_W-1:0] rdata_o,
    input op_e               op,
    input logic              sleep_q,
    input logic              commit,
    input logic              buf_vld,
    input logic [DATA_W-1:0] dout_q
);

    AST_DESEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_i |=> (op == OP_IDLE)); // R7

    AST_SLEEP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i |=> (op == OP_IDLE) && sleep_q); // R8

    AST_SLEEP_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_q |-> !commit); // R8

    AST_READ_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_READ) |-> !commit); // R10

    AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_WRITE) |=> buf_vld); // R6

    AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (op != OP_READ) |=> $stable(dout_q)); // R2

    AST_OE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_i |-> (rdata_o == '0)); // R9

endmodule

bind lw_sram lw_sram_chk #(
    .DATA_W (LANES * LANE_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_i    (cs_i),
    .sleep_i (sleep_i),
    .oe_i    (oe_i),
    .rdata_o (rdata_o),
    .op      (op_q),
    .sleep_q (sleep_q),
    .commit  (commit),
    .buf_vld (buf_vld),
    .dout_q  (dout_q)
);

// File: tb/test_lw_sram.sv
// Self-checking bench for lw_sram: a vector table walked by one loop, then
// directed checks for reset, sleep and the output enable.
module test_lw_sram;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 6;
    localparam int LANES      = 4;
    localparam int LANE_W     = 9;
    localparam int DATA_W     = LANES * LANE_W;
    localparam int NROWS      = 15;
    localparam logic [DATA_W-1:0] JUNK = 36'hBADBADBAD;

    typedef struct packed {
        logic              cs;
        logic              we;
        logic [LANES-1:0]  lanes;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [DATA_W-1:0] exp;
        logic [7:0]        req;
    } vec_t;

    // exp is rdata_o after the edge following this row's capture edge.
    localparam vec_t ROWS [NROWS] = '{
        '{1'b1, 1'b1, 4'hF, 6'd5, 36'h123456789, 36'h000000000, 8'd3}, // R3 write
        '{1'b1, 1'b0, 4'h0, 6'd5, 36'h0,         36'h123456789, 8'd5}, // R5 forward
        '{1'b1, 1'b1, 4'h1, 6'd5, 36'hFFFFFFFFF, 36'h123456789, 8'd2}, // R2 hold
        '{1'b1, 1'b0, 4'h0, 6'd5, 36'h0,         36'h1234567FF, 8'd4}, // R4 lane a
        '{1'b0, 1'b1, 4'hF, 6'd5, 36'h000000000, 36'h1234567FF, 8'd7}, // R7 desel
        '{1'b1, 1'b0, 4'h0, 6'd5, 36'h0,         36'h1234567FF, 8'd7}, // R7 unchanged
        '{1'b1, 1'b1, 4'hF, 6'd7, 36'h000000000, 36'h1234567FF, 8'd2}, // R2 hold
        '{1'b1, 1'b1, 4'hA, 6'd7, 36'hFFFFFFFFF, 36'h1234567FF, 8'd2}, // R2 hold
        '{1'b1, 1'b0, 4'h0, 6'd7, 36'h0,         36'hFF803FE00, 8'd4}, // R4 lanes b,d
        '{1'b1, 1'b0, 4'hF, 6'd7, 36'h0,         36'hFF803FE00, 8'd4}, // R4 we low reads
        '{1'b1, 1'b1, 4'hF, 6'd9, 36'h0ABCDEF01, 36'hFF803FE00, 8'd2}, // R2 hold
        '{1'b1, 1'b1, 4'h4, 6'd9, 36'h555555555, 36'hFF803FE00, 8'd2}, // R2 hold
        '{1'b1, 1'b0, 4'h0, 6'd9, 36'h0,         36'h0AD55EF01, 8'd6}, // R6 newest
        '{1'b1, 1'b0, 4'h0, 6'd5, 36'h0,         36'h1234567FF, 8'd6}, // R6 kept
        '{1'b1, 1'b0, 4'h0, 6'd7, 36'h0,         36'hFF803FE00, 8'd6}  // R6 kept
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic              cs_i;
    logic              we_i;
    logic [LANES-1:0]  lane_we_i;
    logic [ADDR_W-1:0] addr_i;
    logic [DATA_W-1:0] wdata_i;
    logic              sleep_i;
    logic              oe_i;
    logic [DATA_W-1:0] rdata_o;
    logic              drive_o;

    int n_checks = 0;
    int n_fails  = 0;

    lw_sram #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) i_lw_sram (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_i      (cs_i),
        .we_i      (we_i),
        .lane_we_i (lane_we_i),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .sleep_i   (sleep_i),
        .oe_i      (oe_i),
        .rdata_o   (rdata_o),
        .drive_o   (drive_o)
    );

    // Free-running clock.
    always #(CLK_PERIOD / 2) clk = ~clk;

    // Compare one value and report a miscompare.
    task automatic check(input logic [DATA_W-1:0] act,
                         input logic [DATA_W-1:0] exp,
                         input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one cycle's inputs.
    task automatic drive(input logic cs, input logic we, input logic [LANES-1:0] ln,
                         input logic [ADDR_W-1:0] ad, input logic [DATA_W-1:0] wd,
                         input logic slp);
        cs_i      = cs;
        we_i      = we;
        lane_we_i = ln;
        addr_i    = ad;
        wdata_i   = wd;
        sleep_i   = slp;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_PERIOD * 20000);
        n_fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    // Main stimulus.
    initial begin
        logic              prev_wr;
        logic [DATA_W-1:0] prev_data;
        rst_n = 1'b0;
        oe_i  = 1'b1;
        drive(1'b0, 1'b0, '0, '0, '0, 1'b0);
        repeat (3) @(negedge clk);
        // R1: reset state of the output register.
        check(rdata_o, '0, "R1 reset output");
        check({35'd0, drive_o}, 36'd1, "R1 drive after reset");
        rst_n = 1'b1;

        // Table walk; rows beyond the table are idle cycles.
        prev_wr   = 1'b0;
        prev_data = '0;
        for (int j = 0; j < NROWS + 2; j++) begin
            @(negedge clk);
            if (j >= 2) begin
                check(rdata_o, ROWS[j-2].exp,
                      $sformatf("R%0d row %0d", ROWS[j-2].req, j-2));
            end
            if (j < NROWS) begin
                // R3: only the cycle after a write carries its data.
                drive(ROWS[j].cs, ROWS[j].we, ROWS[j].lanes, ROWS[j].addr,
                      prev_wr ? prev_data : JUNK, 1'b0);
                prev_wr   = ROWS[j].cs && ROWS[j].we;
                prev_data = ROWS[j].data;
            end else begin
                drive(1'b0, 1'b0, '0, '0, prev_wr ? prev_data : JUNK, 1'b0);
                prev_wr = 1'b0;
            end
        end

        // R8 and R10: a write whose buffer entry must survive sleep cycles.
        @(negedge clk);
        drive(1'b1, 1'b1, 4'hF, 6'd3, JUNK, 1'b0);
        @(negedge clk);
        drive(1'b1, 1'b0, 4'h0, 6'd5, 36'h00000F00F, 1'b1);
        @(negedge clk);
        drive(1'b1, 1'b0, 4'h0, 6'd5, JUNK, 1'b1);
        @(negedge clk);
        check(rdata_o, 36'hFF803FE00, "R8 output held in sleep");
        drive(1'b1, 1'b0, 4'h0, 6'd3, JUNK, 1'b0);
        @(negedge clk);
        drive(1'b0, 1'b0, 4'h0, 6'd0, JUNK, 1'b0);
        @(negedge clk);
        check(rdata_o, 36'h00000F00F, "R8 R10 pending write after sleep");

        // R9: output enable acts without a clock edge.
        oe_i = 1'b0;
        #1;
        check(rdata_o, '0, "R9 outputs off");
        check({35'd0, drive_o}, 36'd0, "R9 drive off");
        oe_i = 1'b1;
        #1;
        check(rdata_o, 36'h00000F00F, "R9 outputs restored");
        check({35'd0, drive_o}, 36'd1, "R9 drive on");

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule